// File: doc/BRIEF.md
# Control Interface Mode Selector

After reset, this block decides which serial control interface owns a group of shared multifunction pins. It reads a boot-select strap once, on the first clock edge after reset is released. A low strap selects a two-wire I2C slave. A high strap selects a self-boot master, which loads settings from an external serial EEPROM and needs no host. While the block is in I2C mode, a host can move it to four-wire SPI slave mode by pulling the latch pin low three separate times. After that the block stays in SPI mode until the next reset.

The block drives a one-hot mode vector that enables the matching protocol engine. Those engines live outside this block. For each of the four shared pins it also drives an output enable and an open-drain enable, and it drives one enable for the low address-select input. Pin index 0 is the clock pin, 1 is the serial data pin, 2 is the data-in / writeback-trigger pin and 3 is the latch / write-protect pin. An output enable of 1 means the pad is driven. An open-drain enable of 1 means the pad can only pull low. While reset is asserted and the mode is not yet resolved, every pad is a high-impedance input.

Top module: `ctrl_mode_sel`

## Requirements
- R1: While rst_ni is low, and until the first rising clock edge after its release, mode_o is 3'b000, pin_oe_o and pin_od_o are 4'b0000 and addr_en_o is 0.
- R2: If boot_sel_i is low at the first rising edge after reset release, mode_o becomes 3'b001 (bit 0 = I2C) after that edge.
- R3: If boot_sel_i is high at that edge, mode_o becomes 3'b100 (bit 2 = self-boot) and stays there until reset.
- R4: In I2C mode, the third accepted low pulse on latch_pin_i switches mode_o to 3'b010 (bit 1 = SPI). After one or two accepted pulses the mode stays I2C.
- R5: A low level on latch_pin_i that lasts fewer than DEB_CYCLES clock cycles is not counted as a pulse.
- R6: Once in SPI mode, the block stays in SPI mode until reset, whatever the latch pulses that follow.
- R7: Changes on boot_sel_i after the mode is resolved have no effect on mode_o until the next reset.
- R8: In I2C mode, pin_oe_o = 4'b0010, pin_od_o = 4'b0010 and addr_en_o = 1 (clock in, data open-drain, latch pin unused).
- R9: In SPI mode, pin_oe_o = 4'b0010, pin_od_o = 4'b0000 and addr_en_o = 1 (data push-pull, clock, data-in and latch inputs).
- R10: In self-boot mode, pin_oe_o = 4'b1011, pin_od_o = 4'b1010 and addr_en_o = 0 (clock driven, data and write-protect open-drain, writeback-trigger input).
- R11: In self-boot mode, low pulses on latch_pin_i have no effect on the mode.
- R12: mode_o is never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_sel_i | input | 1 | Boot-select strap, read once after reset |
| latch_pin_i | input | 1 | Pad level of the latch pin (asynchronous) |
| mode_o | output | 3 | One-hot mode: bit0 I2C, bit1 SPI, bit2 self-boot; 0 while unresolved |
| pin_oe_o | output | 4 | Per-pin output enable (0 clock, 1 data, 2 data-in/writeback, 3 latch/write-protect) |
| pin_od_o | output | 4 | Per-pin open-drain enable, same indices |
| addr_en_o | output | 1 | Low address-select pin is in use |

## Verification
The assertions assume that boot_sel_i is a static strap during the first edge after reset release. They also assume that latch_pin_i may change at any time but reaches the counter only through the synchronizer and filter. The bench changes boot_sel_i only on falling clock edges, and it changes the strap after resolution only to show that the change is ignored. Latch pulses are either held low and high for well over the filter length, or kept clearly shorter than it to act as glitches.

// File: rtl/ctrl_mode_pkg.sv
package ctrl_mode_pkg;
  localparam int unsigned NUM_PINS  = 4;
  localparam int unsigned NUM_MODES = 3;

  typedef enum logic [1:0] {
    ST_RESOLVE = 2'd0,
    ST_I2C     = 2'd1,
    ST_SPI     = 2'd2,
    ST_BOOT    = 2'd3
  } mode_st_e;

  // mode one-hot bit positions
  localparam int unsigned M_I2C  = 0;
  localparam int unsigned M_SPI  = 1;
  localparam int unsigned M_BOOT = 2;

  // per-pin masks over {boot, spi, i2c}
  localparam logic [NUM_MODES-1:0] OE_MASK [NUM_PINS] = '{3'b100, 3'b111, 3'b000, 3'b100};
  localparam logic [NUM_MODES-1:0] OD_MASK [NUM_PINS] = '{3'b000, 3'b101, 3'b000, 3'b100};
  localparam logic [NUM_MODES-1:0] ADDR_MASK = 3'b011;
endpackage

// File: rtl/cms_pin_filter.sv
module cms_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   filt_q, filt_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   sync_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_lvl != filt_q) begin
      if (cnt_q == CNT_LAST) filt_d = sync_lvl;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
      fall_o <= 1'b0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
      fall_o <= filt_q & ~filt_d;
    end
  end

  // R5: a level change is only accepted after a full run of disagreeing samples
  p_filter_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(sync_lvl) != $past(filt_q)));
endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned PULSES = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     boot_sel_i,
  input  logic     fall_i,
  output mode_st_e st_o
);
  localparam int unsigned PW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSES - 1);
  localparam logic [PW-1:0] P_SAT  = PW'(PULSES);

  mode_st_e      st_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RESOLVE;
      pcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_RESOLVE: st_q <= boot_sel_i ? ST_BOOT : ST_I2C;
        ST_I2C: if (fall_i) begin
          if (pcnt_q == P_LAST) begin
            st_q   <= ST_SPI;
            pcnt_q <= P_SAT;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign st_o = st_q;

  p_spi_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPI) |=> (st_q == ST_SPI));
  p_boot_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BOOT) |=> (st_q == ST_BOOT) && $stable(pcnt_q));
  p_i2c_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_I2C && !(fall_i && pcnt_q == P_LAST)) |=> (st_q == ST_I2C));
  p_no_return_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RESOLVE) |=> (st_q != ST_RESOLVE));
endmodule

// File: rtl/cms_pin_steer.sv
module cms_pin_steer
  import ctrl_mode_pkg::*;
(
  input  mode_st_e              st_i,
  output logic [NUM_MODES-1:0]  mode_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [NUM_PINS-1:0]   pin_od_o,
  output logic                  addr_en_o
);
  always_comb begin
    mode_o = '0;
    unique case (st_i)
      ST_I2C:  mode_o[M_I2C]  = 1'b1;
      ST_SPI:  mode_o[M_SPI]  = 1'b1;
      ST_BOOT: mode_o[M_BOOT] = 1'b1;
      default: ;
    endcase
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_oe_o[p] = |(mode_o & OE_MASK[p]);
    assign pin_od_o[p] = |(mode_o & OD_MASK[p]);
  end

  assign addr_en_o = |(mode_o & ADDR_MASK);

  always_comb begin
    p_onehot_r12: assert ($onehot0(mode_o));
    p_od_needs_oe_r1: assert ((pin_od_o & ~pin_oe_o) == '0);
  end
endmodule

// File: rtl/ctrl_mode_sel.sv
module ctrl_mode_sel
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4,
  parameter int unsigned PULSES      = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boot_sel_i,
  input  logic       latch_pin_i,
  output logic [2:0] mode_o,
  output logic [3:0] pin_oe_o,
  output logic [3:0] pin_od_o,
  output logic       addr_en_o
);
  logic     fall;
  mode_st_e st;

  cms_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (latch_pin_i),
    .fall_o(fall)
  );

  cms_mode_fsm #(.PULSES(PULSES)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .boot_sel_i(boot_sel_i),
    .fall_i    (fall),
    .st_o      (st)
  );

  cms_pin_steer u_steer (
    .st_i     (st),
    .mode_o   (mode_o),
    .pin_oe_o (pin_oe_o),
    .pin_od_o (pin_od_o),
    .addr_en_o(addr_en_o)
  );

  p_boot_pins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[2] |-> (pin_oe_o[0] && pin_od_o[3] && !addr_en_o));
  p_spi_pushpull_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> (pin_oe_o[1] && !pin_od_o[1] && !pin_oe_o[0]));
endmodule

// File: tb/tb_ctrl_mode_sel.sv
module tb_ctrl_mode_sel;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEB = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       boot_sel_i = 1'b0;
  logic       latch_pin_i = 1'b1;
  logic [2:0] mode_o;
  logic [3:0] pin_oe_o, pin_od_o;
  logic       addr_en_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ctrl_mode_sel #(.DEB_CYCLES(DEB)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .boot_sel_i(boot_sel_i), .latch_pin_i(latch_pin_i),
    .mode_o(mode_o), .pin_oe_o(pin_oe_o), .pin_od_o(pin_od_o), .addr_en_o(addr_en_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pins(string tag, logic [3:0] oe, logic [3:0] od, logic ad);
    chk({tag, " oe"}, {4'b0, pin_oe_o}, {4'b0, oe});
    chk({tag, " od"}, {4'b0, pin_od_o}, {4'b0, od});
    chk({tag, " addr"}, {7'b0, addr_en_o}, {7'b0, ad});
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    boot_sel_i = strap;
    latch_pin_i = 1'b1;
    cyc(3);
    chk("R1 reset mode", {5'b0, mode_o}, 8'h00);
    pins("R1 reset", 4'b0000, 4'b0000, 1'b0);
    rst_ni = 1'b1;
    #1;
    chk("R1 unresolved mode", {5'b0, mode_o}, 8'h00);
    cyc(2);
  endtask

  task automatic pulse(int low_len);
    latch_pin_i = 1'b0;
    cyc(low_len);
    latch_pin_i = 1'b1;
    cyc(16);
  endtask

  task automatic t_i2c_default;
    do_reset(1'b0);
    chk("R2 i2c mode", {5'b0, mode_o}, 8'h01);
    pins("R8 i2c", 4'b0010, 4'b0010, 1'b1);
  endtask

  task automatic t_spi_promote;
    pulse(12);
    chk("R4 after 1 pulse", {5'b0, mode_o}, 8'h01);
    pulse(12);
    chk("R4 after 2 pulses", {5'b0, mode_o}, 8'h01);
    pulse(DEB - 2);
    pulse(1);
    chk("R5 glitches ignored", {5'b0, mode_o}, 8'h01);
    pulse(12);
    chk("R4 after 3 pulses", {5'b0, mode_o}, 8'h02);
    pins("R9 spi", 4'b0010, 4'b0000, 1'b1);
  endtask

  task automatic t_spi_sticky;
    for (int i = 0; i < 4; i++) pulse(12);
    chk("R6 spi sticky", {5'b0, mode_o}, 8'h02);
    boot_sel_i = 1'b1;
    cyc(5);
    chk("R7 strap ignored in spi", {5'b0, mode_o}, 8'h02);
  endtask

  task automatic t_boot;
    do_reset(1'b1);
    chk("R3 boot mode", {5'b0, mode_o}, 8'h04);
    pins("R10 boot", 4'b1011, 4'b1010, 1'b0);
    for (int i = 0; i < 4; i++) pulse(12);
    chk("R11 pulses ignored in boot", {5'b0, mode_o}, 8'h04);
    boot_sel_i = 1'b0;
    cyc(5);
    chk("R7 strap ignored in boot", {5'b0, mode_o}, 8'h04);
  endtask

  task automatic t_i2c_strap_change;
    do_reset(1'b0);
    boot_sel_i = 1'b1;
    cyc(5);
    chk("R7 strap ignored in i2c", {5'b0, mode_o}, 8'h01);
    chk("R12 one-hot", {7'b0, $onehot0(mode_o)}, 8'h01);
  endtask

  initial begin
    fork
      begin
        t_i2c_default();
        t_spi_promote();
        t_spi_sticky();
        t_boot();
        t_i2c_strap_change();
      end
      begin
        cyc(50000);
        failures++;
        checks++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule